// File: doc/BRIEF.md
# Speculation Control Register Unit

This block holds the two machine-specific registers that govern branch-prediction isolation. One is a write-only command register that fires a prediction barrier. The other is a control word with two isolation bits: restricted speculation and single-thread isolation. Register requests arrive as an address, a 64-bit write word and a read/write strobe. The block answers one cycle later with read data or a protection-fault flag.

The control word exists twice, once for the host and once for the guest. On virtual-machine entry the guest copy is loaded from a restore port. While a guest runs, the effective isolation bits are the OR of the two copies, so a hypervisor can force protection on for the guest. On exit the guest copy is offered on a save port for the control block held in memory. Parameters choose which isolation bits are implemented and how long a write keeps the issue path stalled.

The predictor receives a one-cycle barrier pulse and a one-cycle "new window" pulse. The new window pulse starts a fresh isolation epoch for restricted speculation.

Top module: `spec_ctl_unit`

## Requirements
- R1: The command register (address 0x49) is write-only. A read of it faults. A write with any one in bits 63:1 also faults. A faulting request changes no state and raises no pulse.
- R2: An accepted command write with bit 0 = 1 drives `barrier_o` high for exactly one cycle, in the cycle after the request. A command write with bit 0 = 0 completes without a pulse.
- R3: In the control register (address 0x48), bit 0 is restricted speculation and bit 1 is single-thread isolation. A write with any one in bits 63:2 faults and leaves both copies unchanged.
- R4: A control bit disabled by parameter never faults when written. It reads as zero, and its effective output stays zero.
- R5: In host mode, control writes update only the host copy. The effective bits equal the host copy.
- R6: `vm_entry_i` in host mode loads the guest copy from `restore_ctl_i`, masked to the implemented bits, and enters guest mode. In guest mode, control writes update only the guest copy, reads return the guest copy, and the effective bits are the host copy ORed with the guest copy.
- R7: `vm_exit_i` in guest mode returns to host mode. In the next cycle `save_valid_o` pulses once. `save_data_o` then holds the guest copy as it was before the exit edge, and `save_offset_o` reads 0x2E0. After the exit, the effective bits equal the host copy.
- R8: Every accepted write that does not fault holds `busy_o` high for BUSY_CYCLES cycles, starting in the next cycle. A request presented while `busy_o` is high is dropped: it gets no response and has no effect.
- R9: An accepted control write with bit 0 = 1, when restricted speculation is implemented, pulses `new_window_o` for one cycle. This happens even if the bit was already set.
- R10: Every accepted request gets `rsp_valid_o` in the next cycle. A control read returns the copy selected by the current mode, with bits 63:2 as zero. Writes and faults return zero data. Reset clears both copies, host mode, all pulses and `busy_o`.
- R11: A request to any address other than the two registers faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write word |
| rsp_valid_o | output | 1 | Response for the previous cycle's accepted request |
| rsp_fault_o | output | 1 | Protection fault on that request |
| rsp_rdata_o | output | DATA_W | Read data |
| busy_o | output | 1 | Write in progress; new requests are dropped |
| barrier_o | output | 1 | One-cycle prediction barrier pulse |
| new_window_o | output | 1 | One-cycle fresh isolation epoch pulse |
| eff_rspec_o | output | 1 | Effective restricted-speculation bit |
| eff_iso_o | output | 1 | Effective single-thread isolation bit |
| vm_entry_i | input | 1 | Virtual-machine entry strobe |
| restore_ctl_i | input | 2 | Guest control word to load on entry |
| vm_exit_i | input | 1 | Virtual-machine exit strobe |
| guest_mode_o | output | 1 | 1 while in guest mode |
| save_valid_o | output | 1 | Guest word is offered for saving |
| save_offset_o | output | 12 | Save slot offset (0x2E0) |
| save_data_o | output | DATA_W | Guest control word, zero-extended |

## Verification
The bench builds two instances side by side. The first uses the defaults: both control bits implemented and BUSY_CYCLES = 2. The second disables single-thread isolation and uses BUSY_CYCLES = 1. The second instance reaches the rule that a write to a missing bit is silently dropped. The two busy lengths show the request-dropping window at two different widths. Directed sequences cover host/guest switching, and these two cases:
- a guest write in the same cycle as an exit;
- a host write in the same cycle as an entry.

A long stretch of random traffic then exercises every ordering of requests, entries and exits.

// File: rtl/spec_ctl_pkg.sv
package spec_ctl_pkg;
  localparam int unsigned CTL_BITS  = 2;
  localparam int unsigned BIT_RSPEC = 0;
  localparam int unsigned BIT_ISO   = 1;
  localparam logic [11:0] SAVE_OFFSET = 12'h2E0;

  typedef enum logic [1:0] {TGT_NONE, TGT_CMD, TGT_CTL} tgt_e;
endpackage

// File: rtl/spec_ctl_decode.sv
module spec_ctl_decode
  import spec_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 64,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h49,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h48,
  parameter logic [CTL_BITS-1:0] IMP_MASK = 2'b11
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              accept_o,
  output logic              fault_o,
  output logic              ctl_wr_o,
  output logic              ctl_rd_o,
  output logic              barrier_req_o,
  output logic              new_win_req_o,
  output logic              wr_done_o
);
  tgt_e tgt;
  logic bad, ok, hi_cmd, hi_ctl;

  always_comb begin
    if (addr_i == CMD_ADDR)      tgt = TGT_CMD;
    else if (addr_i == CTL_ADDR) tgt = TGT_CTL;
    else                         tgt = TGT_NONE;

    hi_cmd = |wdata_i[DATA_W-1:1];
    hi_ctl = |wdata_i[DATA_W-1:CTL_BITS];

    unique case (tgt)
      TGT_CMD: bad = !write_i || hi_cmd;
      TGT_CTL: bad = write_i && hi_ctl;
      default: bad = 1'b1;
    endcase

    accept_o      = valid_i && !busy_i;
    fault_o       = accept_o && bad;
    ok            = accept_o && !bad;
    ctl_wr_o      = ok && write_i && (tgt == TGT_CTL);
    ctl_rd_o      = ok && !write_i && (tgt == TGT_CTL);
    barrier_req_o = ok && write_i && (tgt == TGT_CMD) && wdata_i[0];
    // restricted-speculation write reopens the window even if already set
    new_win_req_o = ctl_wr_o && wdata_i[BIT_RSPEC] && IMP_MASK[BIT_RSPEC];
    wr_done_o     = ok && write_i;
  end
endmodule

// File: rtl/spec_ctl_ctx.sv
module spec_ctl_ctx
  import spec_ctl_pkg::*;
#(
  parameter logic [CTL_BITS-1:0] IMP_MASK = 2'b11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_wr_i,
  input  logic [CTL_BITS-1:0] wdata_i,
  input  logic                vm_entry_i,
  input  logic [CTL_BITS-1:0] restore_i,
  input  logic                vm_exit_i,
  output logic                guest_mode_o,
  output logic [CTL_BITS-1:0] sel_o,
  output logic [CTL_BITS-1:0] eff_o,
  output logic                save_valid_o,
  output logic [CTL_BITS-1:0] save_data_o
);
  logic [CTL_BITS-1:0] host_q, guest_q, save_q;
  logic gm_q, sv_q, do_entry, do_exit;

  assign do_entry = vm_entry_i && !gm_q;
  assign do_exit  = vm_exit_i && gm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_q  <= '0;
      guest_q <= '0;
      gm_q    <= 1'b0;
      sv_q    <= 1'b0;
      save_q  <= '0;
    end else begin
      if (ctl_wr_i && !gm_q) host_q <= wdata_i & IMP_MASK;
      if (do_entry)               guest_q <= restore_i & IMP_MASK;
      else if (ctl_wr_i && gm_q)  guest_q <= wdata_i & IMP_MASK;
      if (do_exit)       gm_q <= 1'b0;
      else if (do_entry) gm_q <= 1'b1;
      sv_q <= do_exit;
      if (do_exit) save_q <= guest_q;
    end
  end

  assign guest_mode_o = gm_q;
  assign sel_o        = gm_q ? guest_q : host_q;
  assign eff_o        = host_q | (gm_q ? guest_q : '0);
  assign save_valid_o = sv_q;
  assign save_data_o  = save_q;

  // R7
  save_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_valid_o |-> !guest_mode_o);
  // R6
  restore_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gm_q) |-> guest_q == ($past(restore_i) & IMP_MASK));
  // R4
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_o & ~IMP_MASK) == '0);
endmodule

// File: rtl/spec_ctl_pulse.sv
module spec_ctl_pulse #(
  parameter int unsigned BUSY_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic barrier_req_i,
  input  logic new_win_req_i,
  input  logic wr_done_i,
  output logic barrier_o,
  output logic new_win_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = (BUSY_CYCLES > 0) ? $clog2(BUSY_CYCLES + 1) : 1;

  logic bar_q, nw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q <= 1'b0;
      nw_q  <= 1'b0;
    end else begin
      bar_q <= barrier_req_i;
      nw_q  <= new_win_req_i;
    end
  end

  assign barrier_o = bar_q;
  assign new_win_o = nw_q;

  generate
    if (BUSY_CYCLES > 0) begin : g_busy
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (wr_done_i)      cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign busy_o = (cnt_q != '0);

      // R8
      busy_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_done_i |=> busy_o);
      // R2
      barrier_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        barrier_o |=> !barrier_o);
    end else begin : g_nobusy
      assign busy_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/spec_ctl_unit.sv
module spec_ctl_unit
  import spec_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 64,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h49,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h48,
  parameter bit          HAS_RSPEC   = 1'b1,
  parameter bit          HAS_ISO     = 1'b1,
  parameter int unsigned BUSY_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              busy_o,
  output logic              barrier_o,
  output logic              new_window_o,
  output logic              eff_rspec_o,
  output logic              eff_iso_o,
  input  logic              vm_entry_i,
  input  logic [1:0]        restore_ctl_i,
  input  logic              vm_exit_i,
  output logic              guest_mode_o,
  output logic              save_valid_o,
  output logic [11:0]       save_offset_o,
  output logic [DATA_W-1:0] save_data_o
);
  localparam logic [CTL_BITS-1:0] IMP_MASK = {HAS_ISO, HAS_RSPEC};

  logic accept, fault, ctl_wr, ctl_rd, bar_req, nw_req, wr_done;
  logic [CTL_BITS-1:0] sel, eff, save_ctl;
  logic rv_q, rf_q;
  logic [DATA_W-1:0] rd_q;

  spec_ctl_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR),
    .CTL_ADDR(CTL_ADDR), .IMP_MASK(IMP_MASK)
  ) u_dec (
    .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i), .busy_i(busy_o), .accept_o(accept),
    .fault_o(fault), .ctl_wr_o(ctl_wr), .ctl_rd_o(ctl_rd),
    .barrier_req_o(bar_req), .new_win_req_o(nw_req), .wr_done_o(wr_done)
  );

  spec_ctl_ctx #(.IMP_MASK(IMP_MASK)) u_ctx (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr),
    .wdata_i(req_wdata_i[CTL_BITS-1:0]), .vm_entry_i(vm_entry_i),
    .restore_i(restore_ctl_i), .vm_exit_i(vm_exit_i),
    .guest_mode_o(guest_mode_o), .sel_o(sel), .eff_o(eff),
    .save_valid_o(save_valid_o), .save_data_o(save_ctl)
  );

  spec_ctl_pulse #(.BUSY_CYCLES(BUSY_CYCLES)) u_pls (
    .clk_i(clk_i), .rst_ni(rst_ni), .barrier_req_i(bar_req),
    .new_win_req_i(nw_req), .wr_done_i(wr_done), .barrier_o(barrier_o),
    .new_win_o(new_window_o), .busy_o(busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0;
      rf_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= accept;
      rf_q <= fault;
      rd_q <= ctl_rd ? DATA_W'(sel) : '0;
    end
  end

  assign rsp_valid_o   = rv_q;
  assign rsp_fault_o   = rf_q;
  assign rsp_rdata_o   = rd_q;
  assign eff_rspec_o   = eff[BIT_RSPEC];
  assign eff_iso_o     = eff[BIT_ISO];
  assign save_offset_o = SAVE_OFFSET;
  assign save_data_o   = DATA_W'(save_ctl);

  // R1
  cmd_read_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !req_write_i && req_addr_i == CMD_ADDR)
      |=> (rsp_valid_o && rsp_fault_o));
  // R8
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rsp_valid_o);
  // R1
  fault_no_barrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> !barrier_o && !new_window_o);
  // R10
  rdata_high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rdata_o[DATA_W-1:CTL_BITS] == '0);
endmodule

// File: tb/sim_spec_ctl_unit.sv
`timescale 1ns/1ps
module sim_spec_ctl_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        vld = 0, wr = 0, ent = 0, ext = 0;
  logic [31:0] addr = '0;
  logic [63:0] wd = '0;
  logic [1:0]  rst_dat = '0;

  logic        a_rv[2], a_rf[2], a_busy[2], a_bar[2], a_nw[2];
  logic        a_er[2], a_ei[2], a_gm[2], a_sv[2];
  logic [63:0] a_rd[2], a_sd[2];
  logic [11:0] a_so[2];

  spec_ctl_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wd), .rsp_valid_o(a_rv[0]),
    .rsp_fault_o(a_rf[0]), .rsp_rdata_o(a_rd[0]), .busy_o(a_busy[0]),
    .barrier_o(a_bar[0]), .new_window_o(a_nw[0]), .eff_rspec_o(a_er[0]),
    .eff_iso_o(a_ei[0]), .vm_entry_i(ent), .restore_ctl_i(rst_dat),
    .vm_exit_i(ext), .guest_mode_o(a_gm[0]), .save_valid_o(a_sv[0]),
    .save_offset_o(a_so[0]), .save_data_o(a_sd[0])
  );

  spec_ctl_unit #(.HAS_ISO(1'b0), .BUSY_CYCLES(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wd), .rsp_valid_o(a_rv[1]),
    .rsp_fault_o(a_rf[1]), .rsp_rdata_o(a_rd[1]), .busy_o(a_busy[1]),
    .barrier_o(a_bar[1]), .new_window_o(a_nw[1]), .eff_rspec_o(a_er[1]),
    .eff_iso_o(a_ei[1]), .vm_entry_i(ent), .restore_ctl_i(rst_dat),
    .vm_exit_i(ext), .guest_mode_o(a_gm[1]), .save_valid_o(a_sv[1]),
    .save_offset_o(a_so[1]), .save_data_o(a_sd[1])
  );

  // reference model
  logic [1:0]  imp[2] = '{2'b11, 2'b01};
  int          bc[2]  = '{2, 1};
  logic [1:0]  host[2], guest[2], sdat[2];
  logic        gm[2], e_rv[2], e_rf[2], e_bar[2], e_nw[2], e_sv[2];
  logic [63:0] e_rd[2];
  int          cnt[2];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        host[k] = 0; guest[k] = 0; sdat[k] = 0; gm[k] = 0; cnt[k] = 0;
        e_rv[k] = 0; e_rf[k] = 0; e_bar[k] = 0; e_nw[k] = 0; e_sv[k] = 0;
        e_rd[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        logic [1:0] old_g;
        logic acc, flt;
        old_g = guest[k];
        acc = vld && (cnt[k] == 0);
        flt = 0;
        e_rv[k] = acc; e_rf[k] = 0; e_rd[k] = 0; e_bar[k] = 0; e_nw[k] = 0;
        e_sv[k] = 0;
        if (acc) begin
          if (addr == 32'h49) begin
            flt = !wr || (wd[63:1] != 0);
            if (!flt) e_bar[k] = wd[0];
          end else if (addr == 32'h48) begin
            if (wr) begin
              flt = (wd[63:2] != 0);
              if (!flt) begin
                if (gm[k]) guest[k] = wd[1:0] & imp[k];
                else       host[k]  = wd[1:0] & imp[k];
                e_nw[k] = wd[0] & imp[k][0];
              end
            end else begin
              e_rd[k] = {62'd0, gm[k] ? old_g : host[k]};
            end
          end else flt = 1;
          e_rf[k] = flt;
        end
        if (acc && wr && !flt) cnt[k] = bc[k];
        else if (cnt[k] > 0)   cnt[k] = cnt[k] - 1;
        if (ext && gm[k]) begin
          e_sv[k] = 1; sdat[k] = old_g; gm[k] = 0;
        end else if (ent && !gm[k]) begin
          guest[k] = rst_dat & imp[k]; gm[k] = 1;
        end
      end
    end
  end

  task automatic cmp(input int k, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s u%0d t=%0t actual=%h expected=%h", what, k, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    for (int k = 0; k < 2; k++) begin
      logic [1:0] eff;
      eff = host[k] | (gm[k] ? guest[k] : 2'b00);
      n_vec++;
      cmp(k, 64'(a_rv[k]),  64'(e_rv[k]),  "R10 rsp_valid");
      cmp(k, 64'(a_rf[k]),  64'(e_rf[k]),  "R1/R3/R11 fault");
      cmp(k, a_rd[k],       e_rd[k],       "R10 rdata");
      cmp(k, 64'(a_bar[k]), 64'(e_bar[k]), "R2 barrier");
      cmp(k, 64'(a_nw[k]),  64'(e_nw[k]),  "R9 new_window");
      cmp(k, 64'(a_busy[k]), 64'(cnt[k] != 0), "R8 busy");
      cmp(k, 64'({a_ei[k], a_er[k]}), 64'(eff), "R5/R6/R4 effective");
      cmp(k, 64'(a_gm[k]),  64'(gm[k]),    "R6 guest_mode");
      cmp(k, 64'(a_sv[k]),  64'(e_sv[k]),  "R7 save_valid");
      cmp(k, a_sd[k],       64'(sdat[k]),  "R7 save_data");
      cmp(k, 64'(a_so[k]),  64'h2E0,       "R7 save_offset");
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic req(input logic w, input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    vld = 1; wr = w; addr = a; wd = d;
    @(negedge clk);
    vld = 0; wr = 0; wd = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vmctl(input logic e, input logic x, input logic [1:0] r);
    @(negedge clk);
    ent = e; ext = x; rst_dat = r;
    @(negedge clk);
    ent = 0; ext = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(2);
    // R10 reset state
    chk(!a_busy[0] && !a_er[0] && !a_ei[0] && !a_gm[0], "R10 reset state",
        {a_busy[0], a_er[0], a_ei[0], a_gm[0]}, 0);
    // R2 barrier and no-pulse write
    req(1, 32'h49, 64'h1);
    chk(a_bar[0] == 1, "R2 barrier pulse", 64'(a_bar[0]), 1);
    idle(4);
    req(1, 32'h49, 64'h0); idle(4);
    // R1 read fault, high-bit fault
    req(0, 32'h49, 64'h0);
    chk(a_rf[0] == 1, "R1 read of command faults", 64'(a_rf[0]), 1);
    idle(2);
    req(1, 32'h49, 64'h2); idle(3);
    req(1, 32'h49, 64'h8000_0000_0000_0001); idle(3);
    // R3/R5/R9 host control
    req(1, 32'h48, 64'h1); idle(3);
    req(1, 32'h48, 64'h1);
    chk(a_nw[0] == 1, "R9 repeated window pulse", 64'(a_nw[0]), 1);
    idle(3);
    req(0, 32'h48, 0); idle(2);
    req(1, 32'h48, 64'h3); idle(3);
    req(0, 32'h48, 0); idle(2);
    req(1, 32'h48, 64'h4); idle(3);
    req(1, 32'h48, 64'h4000_0000_0000_0002); idle(3);
    // R4 missing isolation bit in u1
    req(1, 32'h48, 64'h2); idle(3);
    chk(a_ei[1] == 0 && a_rf[1] == 0, "R4 unimplemented bit", 64'({a_ei[1], a_rf[1]}), 0);
    req(0, 32'h48, 0);
    chk(a_rd[1] == 0, "R4 unimplemented bit reads zero", a_rd[1], 0);
    idle(2);
    // R11 unmapped
    req(0, 32'h50, 0); idle(2);
    req(1, 32'h0, 64'h1); idle(2);
    // R8 dropped during busy
    @(negedge clk); vld = 1; wr = 1; addr = 32'h48; wd = 64'h1;
    @(negedge clk); wr = 0;
    @(negedge clk); vld = 0;
    chk(a_rv[0] == 0, "R8 request dropped while busy", 64'(a_rv[0]), 0);
    idle(4);
    // R6/R7 guest
    req(1, 32'h48, 64'h1); idle(3);
    vmctl(1, 0, 2'b10); idle(1);
    chk(a_er[0] && a_ei[0], "R6 OR of copies", 64'({a_ei[0], a_er[0]}), 3);
    req(0, 32'h48, 0); idle(2);
    req(1, 32'h48, 64'h0); idle(3);
    req(1, 32'h48, 64'h3); idle(3);
    vmctl(0, 1, 2'b00);
    chk(a_sv[0] == 1 && a_sd[0] == 3, "R7 save port", a_sd[0], 3);
    idle(2);
    req(0, 32'h48, 0); idle(2);
    // entry with simultaneous host write; exit with simultaneous guest write
    @(negedge clk); vld = 1; wr = 1; addr = 32'h48; wd = 64'h2; ent = 1; rst_dat = 2'b11;
    @(negedge clk); vld = 0; ent = 0;
    idle(3);
    @(negedge clk); vld = 1; wr = 1; addr = 32'h48; wd = 64'h1; ext = 1;
    @(negedge clk); vld = 0; ext = 0;
    idle(3);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      @(negedge clk);
      r = 4'($urandom);
      vld = r[0];
      wr  = r[1];
      case (2'($urandom))
        2'd0: addr = 32'h49;
        2'd1, 2'd2: addr = 32'h48;
        default: addr = 32'h4A;
      endcase
      wd = ($urandom % 8 == 0) ? {32'($urandom), 32'($urandom)} : 64'($urandom % 4);
      ent = ($urandom % 12 == 0);
      ext = ($urandom % 12 == 0);
      rst_dat = 2'($urandom);
    end
    @(negedge clk);
    vld = 0; ent = 0; ext = 0;
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule